// File: doc/BRIEF.md
# Cycle-Steal DMA Bus Arbiter

This block decides, cycle by cycle, who drives the system bus when several DMA channels move data one access at a time. A channel raises its request line. The arbiter latches that request and grants the bus to one channel for a single stolen access. The access ends when the transfer-done strobe is seen. After every access the DMA side gives the bus back for exactly one cycle. That gap goes to a foreign bus master if one is asking for the bus. Otherwise the bus lies idle for that cycle. Only after the gap does the next channel start, and that channel may differ from the previous one.

Priority among channels is fixed. The lowest channel number wins. A request from a higher-priority channel that arrives during a transfer does not cut that transfer short. It wins the next arbitration, which happens at the end of the gap. Requests from lower-priority channels are held until nothing ahead of them is asking. There is no streaming data path, so every pin is a plain control level.

Top module: `cs_dma_arbiter`

## Requirements
- R1: A cycle with `rst` high, sampled at a clock edge, leaves no grant active and `bus_idle` high from the next cycle onwards. It also forgets every latched channel request.
- R2: With the bus idle or in its one-cycle gap, a request sampled at a clock edge is granted in the next cycle. No extra gap is inserted.
- R3: A channel grant stays unchanged until `xfer_done` is sampled high while that grant is active. `xfer_done` sampled in any other state has no effect on grants or on latched requests.
- R4: In the cycle after a completed transfer, no channel is granted. If `ext_req` was high at the completing edge, `ext_gnt` is high for that cycle. Otherwise `bus_idle` is high for that cycle.
- R5: Each arbitration grants the lowest-numbered channel that is either latched or requesting at that edge. This holds for channels whose requests arrived while another channel was transferring.
- R6: A request pulse of a single cycle is latched. A lower-priority channel keeps its latched request through any number of higher-priority transfers and is served afterwards.
- R7: A channel's latched request clears at the edge where its transfer completes, unless its request input is still high at that edge. If the input is still high, the channel keeps competing.
- R8: When no channel is latched or requesting, `ext_req` high at an edge gives `ext_gnt` in the next cycle. The grant lasts as long as this condition holds. A channel request at an arbitration edge takes precedence over the foreign master.
- R9: The grants `ch_gnt` (one bit per channel, bit i for channel i) and `ext_gnt` are never active together, and `ch_gnt` has at most one bit set. `bus_idle` is high exactly when no grant is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ch_req | input | NCH | Per-channel request, bit i is channel i |
| ext_req | input | 1 | Bus request from the foreign master |
| xfer_done | input | 1 | End of the current stolen access |
| ch_gnt | output | NCH | One-hot channel grant |
| ext_gnt | output | 1 | Bus granted to the foreign master |
| bus_idle | output | 1 | No master owns the bus |

## Verification
A request sampled at edge n shows as a grant one edge later, at n+1. A `xfer_done` sampled at edge n removes the channel grant at edge n+1, and that same edge opens the gap. The next channel grant follows at edge n+2. The bench drives inputs on the falling edge and samples outputs on the next falling edge. Every expected value is therefore read exactly one register stage after its cause. The main sweep covers every non-empty request pattern on a four-channel instance, each with and without a foreign request, and predicts the service order from the positions of the set bits.

// File: rtl/cs_dma_arb_pkg.sv
package cs_dma_arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_XFER    = 2'd1,
    ST_REL_EXT = 2'd2,
    ST_REL_GAP = 2'd3
  } arb_state_e;
endpackage

// File: rtl/cs_prio_pick.sv
// Fixed-priority one-hot picker: the lowest index wins.
module cs_prio_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] pick,
  output logic         any
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_chain
    assign seen[i+1] = seen[i] | req[i];
    assign pick[i]   = req[i] & ~seen[i];
  end
  assign any = seen[N];
endmodule

// File: rtl/cs_pend_latch.sv
// Holds channel requests until their transfer completes.
module cs_pend_latch #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req_in,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) pend[i] <= 1'b0;
      else     pend[i] <= req_in[i] | (pend[i] & ~clr[i]);
    end
  end
endmodule

// File: rtl/cs_arb_fsm.sv
module cs_arb_fsm
  import cs_dma_arb_pkg::*;
#(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pick,
  input  logic         any,
  input  logic         ext_req,
  input  logic         xfer_done,
  output logic [N-1:0] gnt,
  output logic         ext_gnt,
  output logic         bus_idle,
  output logic [N-1:0] clr
);
  arb_state_e st_q, st_n;
  logic [N-1:0] gnt_q, gnt_n;

  always_comb begin
    st_n  = st_q;
    gnt_n = gnt_q;
    if (st_q == ST_XFER) begin
      if (xfer_done) begin
        gnt_n = '0;
        st_n  = ext_req ? ST_REL_EXT : ST_REL_GAP;
      end
    end else begin
      if (any) begin
        st_n  = ST_XFER;
        gnt_n = pick;
      end else begin
        gnt_n = '0;
        st_n  = ext_req ? ST_REL_EXT : ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      gnt_q <= '0;
    end else begin
      st_q  <= st_n;
      gnt_q <= gnt_n;
    end
  end

  assign gnt      = gnt_q;
  assign ext_gnt  = (st_q == ST_REL_EXT);
  assign bus_idle = (st_q == ST_IDLE) || (st_q == ST_REL_GAP);
  assign clr      = gnt_q & {N{(st_q == ST_XFER) && xfer_done}};
endmodule

// File: rtl/cs_dma_arbiter.sv
module cs_dma_arbiter #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] ch_req,
  input  logic           ext_req,
  input  logic           xfer_done,
  output logic [NCH-1:0] ch_gnt,
  output logic           ext_gnt,
  output logic           bus_idle
);
  logic [NCH-1:0] pend, clr, eff, pick;
  logic           any;

  cs_pend_latch #(.N(NCH)) u_pend (
    .clk(clk), .rst(rst), .req_in(ch_req), .clr(clr), .pend(pend)
  );

  assign eff = pend | ch_req;

  cs_prio_pick #(.N(NCH)) u_pick (.req(eff), .pick(pick), .any(any));

  cs_arb_fsm #(.N(NCH)) u_fsm (
    .clk(clk), .rst(rst), .pick(pick), .any(any), .ext_req(ext_req),
    .xfer_done(xfer_done), .gnt(ch_gnt), .ext_gnt(ext_gnt),
    .bus_idle(bus_idle), .clr(clr)
  );
endmodule

// File: rtl/cs_dma_arbiter_chk.sv
module cs_dma_arbiter_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst,
  input logic [NCH-1:0] ch_req,
  input logic           ext_req,
  input logic           xfer_done,
  input logic [NCH-1:0] ch_gnt,
  input logic           ext_gnt,
  input logic           bus_idle
);
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (ch_gnt == '0 && !ext_gnt && bus_idle));

  assert_idle_grants_next_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_idle && ch_req != '0) |=> (ch_gnt != '0));

  assert_grant_held_R3: assert property (@(posedge clk) disable iff (rst)
    (ch_gnt != '0 && !xfer_done) |=> $stable(ch_gnt));

  assert_release_ext_R4: assert property (@(posedge clk) disable iff (rst)
    (ch_gnt != '0 && xfer_done && ext_req) |=> (ext_gnt && ch_gnt == '0));

  assert_release_gap_R4: assert property (@(posedge clk) disable iff (rst)
    (ch_gnt != '0 && xfer_done && !ext_req) |=> (bus_idle && ch_gnt == '0));

  assert_single_grant_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ch_gnt, ext_gnt}));

  assert_idle_flag_R9: assert property (@(posedge clk) disable iff (rst)
    bus_idle == (ch_gnt == '0 && !ext_gnt));
endmodule

bind cs_dma_arbiter cs_dma_arbiter_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .ch_req(ch_req), .ext_req(ext_req),
  .xfer_done(xfer_done), .ch_gnt(ch_gnt), .ext_gnt(ext_gnt),
  .bus_idle(bus_idle)
);

// File: tb/cs_dma_arbiter_tb.sv
module cs_dma_arbiter_tb;
  localparam int NCH = 4;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0] ch_req = '0;
  logic ext_req = 1'b0;
  logic xfer_done = 1'b0;
  logic [NCH-1:0] ch_gnt;
  logic ext_gnt, bus_idle;
  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  cs_dma_arbiter #(.NCH(NCH)) u_dut (
    .clk(clk), .rst(rst), .ch_req(ch_req), .ext_req(ext_req),
    .xfer_done(xfer_done), .ch_gnt(ch_gnt), .ext_gnt(ext_gnt),
    .bus_idle(bus_idle)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // compare full output state: {ch_gnt, ext_gnt, bus_idle}
  task automatic expect_out(input string req, input logic [NCH-1:0] g, input bit e, input bit idl);
    int act, exp;
    act = {ch_gnt, ext_gnt, bus_idle};
    exp = {g, e, idl};
    chk(act == exp, req, act, exp);
    chk($countones({ch_gnt, ext_gnt}) <= 1 && bus_idle == (ch_gnt == '0 && !ext_gnt),
        "R9", act, exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; ch_req = '0; ext_req = 1'b0; xfer_done = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !finished) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state, and reset forgets a latched request
    do_reset();
    expect_out("R1", '0, 0, 1);
    @(negedge clk); ch_req = 4'b1000; rst = 1'b1;
    @(negedge clk); ch_req = '0; rst = 1'b0;
    expect_out("R1", '0, 0, 1);
    @(negedge clk);
    expect_out("R1", '0, 0, 1);

    // R2 R4 R5 R6: sweep every pattern, with and without the foreign master
    for (int e = 0; e < 2; e++) begin
      for (int p = 1; p < (1 << NCH); p++) begin
        do_reset();
        ch_req = p[NCH-1:0]; ext_req = e[0];
        @(negedge clk); ch_req = '0;
        for (int k = 0; k < NCH; k++) begin
          if (p[k]) begin
            expect_out("R5", NCH'(1 << k), 0, 0);
            xfer_done = 1'b1;
            @(negedge clk); xfer_done = 1'b0;
            expect_out("R4", '0, e[0], !e[0]);
            @(negedge clk);
          end
        end
        expect_out("R8", '0, e[0], !e[0]);
      end
    end

    // R3: grant held without done; done during the gap and in idle ignored
    do_reset();
    ch_req = 4'b0110;
    @(negedge clk); ch_req = '0;
    repeat (3) begin
      expect_out("R3", 4'b0010, 0, 0);
      @(negedge clk);
    end
    xfer_done = 1'b1;
    @(negedge clk);                          // gap, done still high
    expect_out("R4", '0, 0, 1);
    @(negedge clk); xfer_done = 1'b0;        // ch2 must survive the stray done
    expect_out("R3", 4'b0100, 0, 0);
    xfer_done = 1'b1;
    @(negedge clk); xfer_done = 1'b0;
    @(negedge clk);
    expect_out("R3", '0, 0, 1);
    xfer_done = 1'b1; ch_req = 4'b1000;      // done in idle together with a request
    @(negedge clk); xfer_done = 1'b0; ch_req = '0;
    expect_out("R2", 4'b1000, 0, 0);
    @(negedge clk);
    expect_out("R3", 4'b1000, 0, 0);
    xfer_done = 1'b1;
    @(negedge clk); xfer_done = 1'b0;
    @(negedge clk);

    // R5: higher-priority arrival during a transfer wins after the gap
    do_reset();
    ch_req = 4'b0100;
    @(negedge clk); ch_req = 4'b1001;
    expect_out("R2", 4'b0100, 0, 0);
    @(negedge clk); ch_req = '0;
    expect_out("R5", 4'b0100, 0, 0);
    xfer_done = 1'b1;
    @(negedge clk); xfer_done = 1'b0;
    expect_out("R4", '0, 0, 1);
    @(negedge clk);
    expect_out("R5", 4'b0001, 0, 0);
    xfer_done = 1'b1;
    @(negedge clk); xfer_done = 1'b0;
    @(negedge clk);
    expect_out("R6", 4'b1000, 0, 0);
    xfer_done = 1'b1;
    @(negedge clk); xfer_done = 1'b0;
    @(negedge clk);

    // R6 R7: held request keeps ch1 competing; ch3 waits, ch1 then clears
    do_reset();
    ch_req = 4'b1010;
    @(negedge clk); ch_req = 4'b0010;
    expect_out("R7", 4'b0010, 0, 0);
    xfer_done = 1'b1;
    @(negedge clk); xfer_done = 1'b0;
    @(negedge clk); ch_req = '0;
    expect_out("R7", 4'b0010, 0, 0);
    xfer_done = 1'b1;
    @(negedge clk); xfer_done = 1'b0;
    @(negedge clk);
    expect_out("R6", 4'b1000, 0, 0);
    xfer_done = 1'b1;
    @(negedge clk); xfer_done = 1'b0;
    @(negedge clk);
    expect_out("R7", '0, 0, 1);

    // R8: foreign master in idle, then a channel takes precedence
    do_reset();
    ext_req = 1'b1;
    @(negedge clk);
    repeat (3) begin
      expect_out("R8", '0, 1, 0);
      @(negedge clk);
    end
    ch_req = 4'b0100;
    @(negedge clk); ch_req = '0;
    expect_out("R8", 4'b0100, 0, 0);
    ext_req = 1'b0;
    xfer_done = 1'b1;
    @(negedge clk); xfer_done = 1'b0;
    expect_out("R4", '0, 0, 1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule